// File: doc/BRIEF.md
# Idle-Triggered Low-Power Mode Controller

This block sits beside a memory controller and watches its idle indication. Once the controller has been idle for a programmed number of clock cycles, the block issues an entry strobe that moves the external memory into one of three low-power modes: clock stop, self-refresh or power-down. The mode code is sparse, and each mode has its own idle threshold, so software can keep all three thresholds loaded and switch between modes by changing only the mode code. A power-down entry can be marked as deep power-down, but only when the deep enable is set and the attached memory is low-power DDR.

An access request ends the idle count at once. If the block is already in a low-power state, the request produces an exit strobe and then a short, fixed exit window during which no new accesses are accepted. The working configuration is written through a write strobe. A separate shadow set can be written at any time and is copied into the working set when the system returns from smart idle. A mode change that arrives while the memory is in low power or leaving it is held back until the block is active again.

Top module: `idle_lp_ctrl`

## Requirements
- R1: Mode codes are 1 = clock stop, 2 = self-refresh and 4 = power-down. While in low power, `lpKind` reports the code of the mode entered and is 0 at all other times. Any other mode code (0, 3, 5, 6, 7) never leads to a low-power entry.
- R2: Each mode counts against its own threshold: `clkStopTimIn` for code 1, `selfRefTimIn` for code 2 and `pwrDownTimIn` for code 4. The other two thresholds have no effect.
- R3: With threshold T, if `idleIn` is high and `accessReq` is low at T consecutive rising edges starting from ACTIVE, the last of those edges moves `lpState` to LOWPOWER (2). `enterStb` is high for exactly that first LOWPOWER cycle. A threshold of 0 behaves as 1.
- R4: While counting (`lpState` = 1), a cycle with `accessReq` high or `idleIn` low returns the block to ACTIVE (0) and clears the count, so that a later entry needs a full T new idle cycles. A request sampled on the same edge that would complete the count wins, and no entry occurs.
- R5: `accessReq` sampled in LOWPOWER moves the block to EXITING (3) with `exitStb` high for that one cycle. The block stays in EXITING for EXIT_CYC cycles (default 2) and then returns to ACTIVE. `accessReady` is low in LOWPOWER and EXITING and high in ACTIVE and COUNTING.
- R6: `deepPd` is high during LOWPOWER only when the entered mode is 4, the deep enable was set and `memType` = 1 (LPDDR). It is low otherwise, including for `memType` 2 or 3.
- R7: A `wakeReload` pulse copies the shadow set (written by `shadowWe` from the same field inputs) into the working set on the next edge. It takes priority over a `cfgWe` in the same cycle.
- R8: A mode change, from `cfgWe` or `wakeReload`, made during LOWPOWER or EXITING leaves `activeMode` unchanged until the first ACTIVE cycle after the exit, where the new code appears.
- R9: After reset, `lpState` is ACTIVE, both strobes and `deepPd` are low, `lpKind` and `activeMode` are 0, and `accessReady` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| idleIn | input | 1 | Memory controller is idle |
| accessReq | input | 1 | Access pending; forces wake-up |
| memType | input | 2 | Memory type, 1 = LPDDR |
| cfgWe | input | 1 | Write the field inputs into the working set |
| shadowWe | input | 1 | Write the field inputs into the shadow set |
| wakeReload | input | 1 | Smart-idle return: copy the shadow set into the working set |
| modeIn | input | 3 | Mode code field |
| clkStopTimIn | input | TIM_W | Clock-stop idle threshold |
| selfRefTimIn | input | TIM_W | Self-refresh idle threshold |
| pwrDownTimIn | input | TIM_W | Power-down idle threshold |
| deepPdEnIn | input | 1 | Deep power-down enable |
| enterStb | output | 1 | Low-power entry strobe |
| exitStb | output | 1 | Low-power exit strobe |
| lpState | output | 2 | 0 ACTIVE, 1 COUNTING, 2 LOWPOWER, 3 EXITING |
| lpKind | output | 3 | Mode code currently in effect at the memory, 0 when not in low power |
| deepPd | output | 1 | Current low-power state is deep power-down |
| accessReady | output | 1 | New accesses accepted |
| activeMode | output | 3 | Mode code of the working set |

## Verification
Two events can fall in the same cycle: the idle count reaching its threshold and an access request arriving. The bench holds `idleIn` high and raises `accessReq` so that the request is sampled on exactly the edge that would complete the count. It then requires `lpState` to read ACTIVE with no entry strobe. A fresh entry must follow a full threshold after the request drops. A second collision, `wakeReload` together with `cfgWe`, is judged by which mode code and threshold take effect.

// File: rtl/lpm_pkg.sv
package lpm_pkg;

  typedef enum logic [1:0] {
    ST_ACTIVE   = 2'd0,
    ST_COUNTING = 2'd1,
    ST_LOWPOWER = 2'd2,
    ST_EXITING  = 2'd3
  } lpmState_t;

  localparam logic [2:0] MODE_CLKSTOP = 3'd1;
  localparam logic [2:0] MODE_SELFREF = 3'd2;
  localparam logic [2:0] MODE_PWRDOWN = 3'd4;
  localparam logic [1:0] MEM_LPDDR    = 2'd1;

  // strobes from control to the configuration datapath
  typedef struct packed {
    logic holdMode;      // mode updates must be parked
    logic applyPending;  // last exit cycle: release a parked mode
  } lpmCtl_t;

endpackage

// File: rtl/lpm_cfg.sv
module lpm_cfg
  import lpm_pkg::*;
#(
  parameter int TIM_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  lpmCtl_t          ctl,
  input  logic             cfgWe,
  input  logic             shadowWe,
  input  logic             wakeReload,
  input  logic [2:0]       modeIn,
  input  logic [TIM_W-1:0] csTimIn,
  input  logic [TIM_W-1:0] srTimIn,
  input  logic [TIM_W-1:0] pdTimIn,
  input  logic             dpdEnIn,
  input  logic [1:0]       memType,
  output logic [2:0]       workMode,
  output logic [TIM_W-1:0] selTim,
  output logic             modeValid,
  output logic             deepOk
);

  logic [TIM_W-1:0] wCs, wSr, wPd, sCs, sSr, sPd;
  logic [2:0]       sMode, pendMode;
  logic             wDpd, sDpd, pendValid;

  // update source: reload beats a plain write
  logic             upd;
  logic [2:0]       srcMode;
  logic [TIM_W-1:0] srcCs, srcSr, srcPd;
  logic             srcDpd;

  always_comb begin
    upd     = wakeReload | cfgWe;
    srcMode = wakeReload ? sMode : modeIn;
    srcCs   = wakeReload ? sCs   : csTimIn;
    srcSr   = wakeReload ? sSr   : srTimIn;
    srcPd   = wakeReload ? sPd   : pdTimIn;
    srcDpd  = wakeReload ? sDpd  : dpdEnIn;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      sMode <= '0; sCs <= '0; sSr <= '0; sPd <= '0; sDpd <= 1'b0;
    end else if (shadowWe) begin
      sMode <= modeIn; sCs <= csTimIn; sSr <= srTimIn; sPd <= pdTimIn; sDpd <= dpdEnIn;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      workMode <= '0; wCs <= '0; wSr <= '0; wPd <= '0; wDpd <= 1'b0;
      pendMode <= '0; pendValid <= 1'b0;
    end else begin
      if (upd) begin
        wCs <= srcCs; wSr <= srcSr; wPd <= srcPd; wDpd <= srcDpd;
        if (ctl.holdMode) begin
          pendMode  <= srcMode;
          pendValid <= 1'b1;
        end else begin
          workMode  <= srcMode;
          pendValid <= 1'b0;
        end
      end else if (ctl.applyPending && pendValid) begin
        workMode  <= pendMode;
        pendValid <= 1'b0;
      end
    end
  end

  always_comb begin
    modeValid = 1'b1;
    selTim    = '0;
    case (workMode)
      MODE_CLKSTOP: selTim = wCs;
      MODE_SELFREF: selTim = wSr;
      MODE_PWRDOWN: selTim = wPd;
      default:      modeValid = 1'b0;
    endcase
    deepOk = (workMode == MODE_PWRDOWN) && wDpd && (memType == MEM_LPDDR);
  end

  assert_mode_frozen_R8: assert property (@(posedge clk) disable iff (!rstN)
    ctl.holdMode |=> $stable(workMode));

  assert_reload_wins_R7: assert property (@(posedge clk) disable iff (!rstN)
    (wakeReload && !ctl.holdMode) |=> (workMode == $past(sMode)));

endmodule

// File: rtl/lpm_ctrl.sv
module lpm_ctrl
  import lpm_pkg::*;
#(
  parameter int TIM_W    = 8,
  parameter int EXIT_CYC = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             idleIn,
  input  logic             accessReq,
  input  logic [2:0]       workMode,
  input  logic [TIM_W-1:0] selTim,
  input  logic             modeValid,
  input  logic             deepOk,
  output lpmCtl_t          ctl,
  output lpmState_t        state,
  output logic             enterStb,
  output logic             exitStb,
  output logic [2:0]       lpKind,
  output logic             deepPd
);

  localparam int EX_W = (EXIT_CYC > 1) ? $clog2(EXIT_CYC) : 1;
  localparam logic [EX_W-1:0] EXIT_LAST = EX_W'(EXIT_CYC - 1);

  lpmState_t        stNext;
  logic [TIM_W-1:0] cnt, cntNext;
  logic [TIM_W:0]   cntInc;
  logic [EX_W-1:0]  exitCnt, exNext;
  logic             enterN, exitN, deepN;
  logic [2:0]       kindN;
  logic             reach;

  always_comb begin
    cntInc  = {1'b0, cnt} + 1'b1;
    reach   = cntInc >= {1'b0, selTim};
    stNext  = state;
    cntNext = cnt;
    exNext  = exitCnt;
    enterN  = 1'b0;
    exitN   = 1'b0;
    kindN   = lpKind;
    deepN   = deepPd;
    case (state)
      ST_ACTIVE, ST_COUNTING: begin
        if (idleIn && !accessReq && modeValid) begin
          if (reach) begin
            stNext  = ST_LOWPOWER;
            cntNext = '0;
            enterN  = 1'b1;
            kindN   = workMode;
            deepN   = deepOk;
          end else begin
            stNext  = ST_COUNTING;
            cntNext = cntInc[TIM_W-1:0];
          end
        end else begin
          stNext  = ST_ACTIVE;
          cntNext = '0;
        end
      end
      ST_LOWPOWER: begin
        if (accessReq) begin
          stNext = ST_EXITING;
          exNext = '0;
          exitN  = 1'b1;
          kindN  = '0;
          deepN  = 1'b0;
        end
      end
      default: begin
        if (exitCnt == EXIT_LAST) stNext = ST_ACTIVE;
        else                      exNext = exitCnt + 1'b1;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state    <= ST_ACTIVE;
      cnt      <= '0;
      exitCnt  <= '0;
      enterStb <= 1'b0;
      exitStb  <= 1'b0;
      lpKind   <= '0;
      deepPd   <= 1'b0;
    end else begin
      state    <= stNext;
      cnt      <= cntNext;
      exitCnt  <= exNext;
      enterStb <= enterN;
      exitStb  <= exitN;
      lpKind   <= kindN;
      deepPd   <= deepN;
    end
  end

  always_comb begin
    ctl.applyPending = (state == ST_EXITING) && (exitCnt == EXIT_LAST);
    ctl.holdMode     = ((state == ST_LOWPOWER) || (state == ST_EXITING)) && !ctl.applyPending;
  end

  assert_req_clears_count_R4: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_COUNTING && accessReq) |=> (state == ST_ACTIVE && !enterStb));

  assert_enter_valid_mode_R1: assert property (@(posedge clk) disable iff (!rstN)
    enterStb |-> ($past(modeValid) && lpKind == $past(workMode) && state == ST_LOWPOWER));

  assert_exit_on_request_R5: assert property (@(posedge clk) disable iff (!rstN)
    exitStb |-> ($past(accessReq) && state == ST_EXITING));

  assert_deep_only_pd_R6: assert property (@(posedge clk) disable iff (!rstN)
    deepPd |-> (lpKind == MODE_PWRDOWN && state == ST_LOWPOWER));

  assert_single_strobe_R3: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({enterStb, exitStb}));

endmodule

// File: rtl/idle_lp_ctrl.sv
module idle_lp_ctrl
  import lpm_pkg::*;
#(
  parameter int TIM_W    = 8,
  parameter int EXIT_CYC = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             idleIn,
  input  logic             accessReq,
  input  logic [1:0]       memType,
  input  logic             cfgWe,
  input  logic             shadowWe,
  input  logic             wakeReload,
  input  logic [2:0]       modeIn,
  input  logic [TIM_W-1:0] clkStopTimIn,
  input  logic [TIM_W-1:0] selfRefTimIn,
  input  logic [TIM_W-1:0] pwrDownTimIn,
  input  logic             deepPdEnIn,
  output logic             enterStb,
  output logic             exitStb,
  output logic [1:0]       lpState,
  output logic [2:0]       lpKind,
  output logic             deepPd,
  output logic             accessReady,
  output logic [2:0]       activeMode
);

  lpmCtl_t          ctl;
  lpmState_t        state;
  logic [2:0]       workMode;
  logic [TIM_W-1:0] selTim;
  logic             modeValid, deepOk;

  lpm_cfg #(.TIM_W(TIM_W)) u_cfg (
    .clk(clk), .rstN(rstN), .ctl(ctl),
    .cfgWe(cfgWe), .shadowWe(shadowWe), .wakeReload(wakeReload),
    .modeIn(modeIn), .csTimIn(clkStopTimIn), .srTimIn(selfRefTimIn),
    .pdTimIn(pwrDownTimIn), .dpdEnIn(deepPdEnIn), .memType(memType),
    .workMode(workMode), .selTim(selTim), .modeValid(modeValid), .deepOk(deepOk)
  );

  lpm_ctrl #(.TIM_W(TIM_W), .EXIT_CYC(EXIT_CYC)) u_ctrl (
    .clk(clk), .rstN(rstN), .idleIn(idleIn), .accessReq(accessReq),
    .workMode(workMode), .selTim(selTim), .modeValid(modeValid), .deepOk(deepOk),
    .ctl(ctl), .state(state), .enterStb(enterStb), .exitStb(exitStb),
    .lpKind(lpKind), .deepPd(deepPd)
  );

  assign lpState     = state;
  assign accessReady = (state == ST_ACTIVE) || (state == ST_COUNTING);
  assign activeMode  = workMode;

  assert_ready_tracks_state_R5: assert property (@(posedge clk) disable iff (!rstN)
    (exitStb || enterStb) |-> !accessReady);

endmodule

// File: tb/idle_lp_ctrl_bench.sv
module idle_lp_ctrl_bench;

  localparam int TIM_W = 8;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic idleIn = 1'b0, accessReq = 1'b0;
  logic [1:0] memType = 2'd3;
  logic cfgWe = 1'b0, shadowWe = 1'b0, wakeReload = 1'b0;
  logic [2:0] modeIn = '0;
  logic [TIM_W-1:0] csTim = '0, srTim = '0, pdTim = '0;
  logic dpdEn = 1'b0;
  logic enterStb, exitStb, deepPd, accessReady;
  logic [1:0] lpState;
  logic [2:0] lpKind, activeMode;

  always #2 clk = ~clk;

  idle_lp_ctrl #(.TIM_W(TIM_W), .EXIT_CYC(2)) u_idle_lp_ctrl (
    .clk(clk), .rstN(rstN), .idleIn(idleIn), .accessReq(accessReq), .memType(memType),
    .cfgWe(cfgWe), .shadowWe(shadowWe), .wakeReload(wakeReload), .modeIn(modeIn),
    .clkStopTimIn(csTim), .selfRefTimIn(srTim), .pwrDownTimIn(pdTim), .deepPdEnIn(dpdEn),
    .enterStb(enterStb), .exitStb(exitStb), .lpState(lpState), .lpKind(lpKind),
    .deepPd(deepPd), .accessReady(accessReady), .activeMode(activeMode)
  );

  typedef struct {
    bit         isExit;
    int         cyc;
    logic [2:0] kind;
    logic       deep;
    string      req;
  } expItem_t;

  expItem_t expQ[$];
  int checks = 0, fails = 0, cycleCnt = 0;
  bit done = 0;

  always @(posedge clk) cycleCnt <= cycleCnt + 1;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d (cycle %0d)", req, act, exp, cycleCnt);
    end
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  endtask

  // monitor: every strobe must match the next expected item
  always @(negedge clk) begin
    if (rstN && (enterStb || exitStb)) begin
      if (expQ.size() == 0) begin
        chk(0, "R3 unexpected strobe", {30'd0, exitStb, enterStb}, 0);
      end else begin
        expItem_t e;
        e = expQ.pop_front();
        chk(e.isExit == exitStb && e.isExit != enterStb, {e.req, " strobe kind"},
            exitStb, e.isExit);
        chk(cycleCnt == e.cyc, {e.req, " strobe cycle"}, cycleCnt, e.cyc);
        if (!e.isExit) begin
          chk(lpKind == e.kind, {e.req, " lpKind"}, lpKind, e.kind);
          chk(deepPd == e.deep, {e.req, " deepPd"}, deepPd, e.deep);
        end
      end
    end
  end

  task automatic setBus(input logic [2:0] m, input int cs, input int sr, input int pd, input logic d);
    modeIn = m; csTim = TIM_W'(cs); srTim = TIM_W'(sr); pdTim = TIM_W'(pd); dpdEn = d;
  endtask

  task automatic writeCfg(input logic [2:0] m, input int cs, input int sr, input int pd, input logic d);
    @(negedge clk);
    setBus(m, cs, sr, pd, d);
    cfgWe = 1'b1;
    @(negedge clk);
    cfgWe = 1'b0;
  endtask

  // raise idle and expect an entry T cycles later (T=0 acts as 1)
  task automatic idleEnter(input int t, input logic [2:0] kind, input logic deep, input string req);
    int tt;
    tt = (t == 0) ? 1 : t;
    @(negedge clk);
    idleIn = 1'b1;
    expQ.push_back('{isExit: 0, cyc: cycleCnt + tt, kind: kind, deep: deep, req: req});
    repeat (tt) @(negedge clk);
    chk(lpState == 2'd2, {req, " state LOWPOWER"}, lpState, 2);
    chk(lpKind == kind, {req, " lpKind held"}, lpKind, kind);
  endtask

  task automatic wake(input logic [2:0] oldMode, input logic [2:0] newMode);
    @(negedge clk);
    idleIn = 1'b0;
    accessReq = 1'b1;
    expQ.push_back('{isExit: 1, cyc: cycleCnt + 1, kind: 0, deep: 0, req: "R5 exit"});
    @(negedge clk);
    accessReq = 1'b0;
    chk(lpState == 2'd3 && !accessReady, "R5 exiting first cycle", lpState, 3);
    chk(lpKind == 3'd0 && !deepPd, "R1 lpKind cleared on exit", lpKind, 0);
    @(negedge clk);
    chk(lpState == 2'd3, "R5 exiting second cycle", lpState, 3);
    chk(activeMode == oldMode, "R8 mode parked during exit", activeMode, oldMode);
    @(negedge clk);
    chk(lpState == 2'd0 && accessReady, "R5 back to active", lpState, 0);
    chk(activeMode == newMode, "R8 mode applied on return", activeMode, newMode);
  endtask

  task automatic idleNoEntry(input int n, input string req);
    @(negedge clk);
    idleIn = 1'b1;
    repeat (n) @(negedge clk);
    chk(lpState != 2'd2, req, lpState, 0);
    idleIn = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    chk(lpState == 2'd0, "R9 reset state", lpState, 0);
    chk(!enterStb && !exitStb && !deepPd, "R9 reset strobes", {enterStb, exitStb, deepPd}, 0);
    chk(lpKind == 3'd0 && activeMode == 3'd0, "R9 reset modes", activeMode, 0);
    chk(accessReady, "R9 reset ready", accessReady, 1);

    // R1: disabled and unassigned codes never enter
    idleNoEntry(12, "R1 mode 0 stays out");
    for (int m = 3; m <= 7; m += 2) begin
      writeCfg(3'(m), 2, 2, 2, 1'b0);
      idleNoEntry(12, "R1 invalid code stays out");
    end

    // R2/R3: clock stop uses its own threshold
    writeCfg(3'd1, 5, 9, 3, 1'b0);
    idleEnter(5, 3'd1, 1'b0, "R2 R3 clock stop");
    chk(!accessReady, "R5 not ready in low power", accessReady, 0);
    wake(3'd1, 3'd1);

    // R2: self-refresh threshold
    writeCfg(3'd2, 5, 9, 3, 1'b0);
    idleEnter(9, 3'd2, 1'b0, "R2 self refresh");
    wake(3'd2, 3'd2);

    // R6: power-down, deep only with LPDDR and enable
    writeCfg(3'd4, 5, 9, 3, 1'b1);
    idleEnter(3, 3'd4, 1'b0, "R6 pd non-LPDDR");
    wake(3'd4, 3'd4);
    memType = 2'd1;
    idleEnter(3, 3'd4, 1'b1, "R6 deep pd");
    wake(3'd4, 3'd4);
    writeCfg(3'd4, 5, 9, 3, 1'b0);
    idleEnter(3, 3'd4, 1'b0, "R6 pd enable off");
    wake(3'd4, 3'd4);
    memType = 2'd3;

    // R3: threshold 0 behaves as 1
    writeCfg(3'd1, 0, 9, 3, 1'b0);
    idleEnter(0, 3'd1, 1'b0, "R3 zero threshold");
    wake(3'd1, 3'd1);

    // R4: request mid-count restarts the count
    writeCfg(3'd1, 5, 9, 3, 1'b0);
    @(negedge clk);
    idleIn = 1'b1;
    repeat (3) @(negedge clk);
    accessReq = 1'b1;
    @(negedge clk);
    chk(lpState == 2'd0, "R4 request clears count", lpState, 0);
    accessReq = 1'b0;
    expQ.push_back('{isExit: 0, cyc: cycleCnt + 5, kind: 3'd1, deep: 0, req: "R4 full recount"});
    repeat (5) @(negedge clk);
    chk(lpState == 2'd2, "R4 entry after recount", lpState, 2);
    wake(3'd1, 3'd1);

    // R4: request on the completing edge wins
    @(negedge clk);
    idleIn = 1'b1;
    repeat (4) @(negedge clk);
    accessReq = 1'b1;
    @(negedge clk);
    chk(lpState == 2'd0 && !enterStb, "R4 request beats entry", lpState, 0);
    accessReq = 1'b0;
    expQ.push_back('{isExit: 0, cyc: cycleCnt + 5, kind: 3'd1, deep: 0, req: "R4 entry after collision"});
    repeat (5) @(negedge clk);
    chk(lpState == 2'd2, "R4 entry after collision state", lpState, 2);

    // R8: mode write in low power is parked until active
    writeCfg(3'd2, 5, 9, 3, 1'b0);
    chk(activeMode == 3'd1 && lpKind == 3'd1, "R8 mode parked in low power", activeMode, 1);
    wake(3'd1, 3'd2);
    idleEnter(9, 3'd2, 1'b0, "R8 new mode after exit");
    wake(3'd2, 3'd2);

    // R7: reload from shadow beats a same-cycle write
    @(negedge clk);
    setBus(3'd4, 6, 6, 3, 1'b0);
    shadowWe = 1'b1;
    @(negedge clk);
    shadowWe = 1'b0;
    chk(activeMode == 3'd2, "R7 shadow write leaves working set", activeMode, 2);
    setBus(3'd1, 7, 7, 10, 1'b0);
    cfgWe = 1'b1;
    wakeReload = 1'b1;
    @(negedge clk);
    cfgWe = 1'b0;
    wakeReload = 1'b0;
    chk(activeMode == 3'd4, "R7 reload wins", activeMode, 4);
    idleEnter(3, 3'd4, 1'b0, "R7 reloaded threshold");
    wake(3'd4, 3'd4);

    repeat (4) @(negedge clk);
    chk(expQ.size() == 0, "R3 all expected strobes seen", expQ.size(), 0);
    finishRun();
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finishRun();
  end

endmodule